// File: doc/BRIEF.md
# Column-Command Latency Scheduler

This block belongs to a double-data-rate memory controller. For every read or write column command it works out the clock cycle in which data has to be captured or driven, and it produces one enable strobe per clock cycle of the data window. A read starts capturing data at read latency, the sum of additive latency and CAS latency. A write starts driving data at write latency, the sum of additive latency and CAS write latency. Data moves on both clock edges, so each cycle of the window carries two beats.

The latency settings come from a shadow register that is loaded from the controller's mode configuration. A load is accepted only while the scheduler is idle. Commands are placed in a shift pipeline that holds one slot per future clock cycle. Because of this, commands issued one burst apart give windows with no gap between them, and a read whose window overlaps a write window is reported rather than dropped.

Top module: `ddr3_lat_sched`

## Requirements
- R1: After a read command is sampled, `rd_en` is first high exactly RL = AL + CL cycles later, counting the command's own cycle as cycle 0.
- R2: After a write command is sampled, `wr_en` is first high exactly WL = AL + CWL cycles later.
- R3: `cfg_al` encodes additive latency as follows: 0 gives zero, 1 gives CL-1, 2 gives CL-2. The code 3 is illegal and raises `cfg_err`.
- R4: `cfg_err` is high while the stored CL is outside {5,6,7,8,9,10,11,13,14} or the stored CWL is outside 5..10. While `cfg_err` is high, commands are ignored and produce no enable.
- R5: `cfg_blm` selects the burst length. 0 gives 8 beats (4 enable cycles) and 1 gives 4 beats (2 enable cycles). With bit 1 set, the length is chosen per command: `cmd_bc4`=1 gives 4 beats and 0 gives 8 beats.
- R6: While an enable is high, `beat_cnt` shows the first beat of the current cycle (0, 2, 4, 6). `burst_done` is high in the last cycle of each window. Both are 0 when no enable is high.
- R7: Two same-direction commands spaced by the burst duration give one unbroken enable window.
- R8: When a new command's window overlaps a window of the opposite direction, `collision_err` pulses in the cycle after that command. Both windows are still produced.
- R9: A configuration load is rejected if any window is pending or a command is presented in the same cycle. `mode_rej` then pulses the following cycle and the old settings stay in force.
- R10: `flush` clears every pending window, so both enables are 0 in the next cycle and stay 0.
- R11: If `cmd_rd` and `cmd_wr` are both high, only the read is scheduled.
- R12: After reset the block is idle: enables, `beat_cnt`, `burst_done`, `collision_err` and `mode_rej` are 0, and the reset settings are legal (`cfg_err`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of pending windows |
| cfg_load | input | 1 | Load request for the latency settings |
| cfg_cl | input | 4 | CAS latency to load |
| cfg_cwl | input | 4 | CAS write latency to load |
| cfg_al | input | 2 | Additive latency code to load |
| cfg_blm | input | 2 | Burst length mode to load |
| cmd_rd | input | 1 | Read column command |
| cmd_wr | input | 1 | Write column command |
| cmd_bc4 | input | 1 | Per-command 4-beat flag when per-command length is selected |
| rd_en | output | 1 | Read capture enable |
| wr_en | output | 1 | Write data enable |
| beat_cnt | output | 3 | First beat index of the current cycle |
| burst_done | output | 1 | Last cycle of a window |
| collision_err | output | 1 | Read/write window overlap pulse |
| cfg_err | output | 1 | Stored settings are illegal |
| mode_rej | output | 1 | Configuration load rejected pulse |

## Verification
A slot that is written at the wrong pipeline depth moves the first enable cycle by the same amount, and this shows up at the port RL or WL cycles after the command. A wrong insertion length or a wrong chop decode changes the number of enable cycles or where `burst_done` falls within that same window. Faults in the shadow register or in the busy tracking show at the ports in one of three ways: a latency change after a load that should have been rejected, a missing `mode_rej` pulse one cycle after the load, or enables that continue after `flush`.

// File: rtl/lat_pkg.sv
package lat_pkg;

  localparam int unsigned LAT_W  = 5;
  localparam int unsigned MAX_CL = 14;

  typedef enum logic [1:0] {
    AL_ZERO = 2'd0,
    AL_CLM1 = 2'd1,
    AL_CLM2 = 2'd2,
    AL_BAD  = 2'd3
  } al_mode_e;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic [1:0] idx;
    logic       last;
  } slot_t;

  function automatic logic cl_ok(input logic [3:0] v);
    case (v)
      4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11, 4'd13, 4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic cwl_ok(input logic [3:0] v);
    return (v >= 4'd5) && (v <= 4'd10);
  endfunction

endpackage

// File: rtl/lat_cfg.sv
module lat_cfg
  import lat_pkg::*;
#(
  parameter logic [3:0] RST_CL  = 4'd5,
  parameter logic [3:0] RST_CWL = 4'd5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             busy,
  input  logic [3:0]       cl_in,
  input  logic [3:0]       cwl_in,
  input  logic [1:0]       al_in,
  input  logic [1:0]       blm_in,
  output logic [LAT_W-1:0] rl,
  output logic [LAT_W-1:0] wl,
  output logic             bc4_fix,
  output logic             otf,
  output logic             cfg_err,
  output logic             mode_rej
);

  logic [3:0] cl_q, cwl_q;
  logic [1:0] al_q, blm_q;
  logic       rej_q;
  logic       take, rej_n;
  logic [LAT_W-1:0] al_val;

  // a load is taken only when nothing is pending
  always_comb begin
    take  = load && !busy;
    rej_n = load && busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_q  <= RST_CL;
      cwl_q <= RST_CWL;
      al_q  <= AL_ZERO;
      blm_q <= 2'd0;
    end else if (take) begin
      cl_q  <= cl_in;
      cwl_q <= cwl_in;
      al_q  <= al_in;
      blm_q <= blm_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rej_q <= 1'b0;
    else        rej_q <= rej_n;
  end

  always_comb begin
    case (al_mode_e'(al_q))
      AL_CLM1: al_val = {1'b0, cl_q} - LAT_W'(1);
      AL_CLM2: al_val = {1'b0, cl_q} - LAT_W'(2);
      default: al_val = '0;
    endcase
    rl       = {1'b0, cl_q} + al_val;
    wl       = {1'b0, cwl_q} + al_val;
    otf      = blm_q[1];
    bc4_fix  = blm_q[0];
    cfg_err  = !cl_ok(cl_q) || !cwl_ok(cwl_q) || (al_q == AL_BAD);
    mode_rej = rej_q;
  end

endmodule

// File: rtl/lat_pipe.sv
module lat_pipe
  import lat_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ins_rd,
  input  logic             ins_wr,
  input  logic [LAT_W-1:0] start,
  input  logic             short_b,
  output slot_t            head,
  output logic             busy,
  output logic             coll
);

  slot_t q     [DEPTH];
  slot_t nxt   [DEPTH];
  logic  coll_q, coll_n;

  always_comb begin
    int s, d;
    s = int'(start);
    d = short_b ? 2 : 4;
    coll_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      nxt[i] = (i < DEPTH - 1) ? q[i+1] : '0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if ((ins_rd || ins_wr) && (i >= s) && (i < s + d)) begin
        if (ins_rd) begin
          coll_n    = coll_n | nxt[i].wr;
          nxt[i].rd = 1'b1;
        end else begin
          coll_n    = coll_n | nxt[i].rd;
          nxt[i].wr = 1'b1;
        end
        nxt[i].idx  = 2'(i - s);
        nxt[i].last = (i == s + d - 1);
      end
    end
    if (flush) begin
      coll_n = 1'b0;
      for (int i = 0; i < DEPTH; i++) nxt[i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
      coll_q <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) q[i] <= nxt[i];
      coll_q <= coll_n;
    end
  end

  always_comb begin
    busy = 1'b0;
    for (int i = 0; i < DEPTH; i++) busy = busy | q[i].rd | q[i].wr;
    head = q[0];
    coll = coll_q;
  end

endmodule

// File: rtl/ddr3_lat_sched.sv
module ddr3_lat_sched
  import lat_pkg::*;
#(
  parameter int unsigned MAXL  = MAX_CL,
  parameter logic [3:0]  RST_CL  = 4'd5,
  parameter logic [3:0]  RST_CWL = 4'd5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       cfg_load,
  input  logic [3:0] cfg_cl,
  input  logic [3:0] cfg_cwl,
  input  logic [1:0] cfg_al,
  input  logic [1:0] cfg_blm,
  input  logic       cmd_rd,
  input  logic       cmd_wr,
  input  logic       cmd_bc4,
  output logic       rd_en,
  output logic       wr_en,
  output logic [2:0] beat_cnt,
  output logic       burst_done,
  output logic       collision_err,
  output logic       cfg_err,
  output logic       mode_rej
);

  // longest latency is CL + (CL-1), plus a 4-cycle window
  localparam int unsigned DEPTH = 2 * MAXL + 4;

  logic [LAT_W-1:0] rl, wl, start;
  logic             bc4_fix, otf, short_b;
  logic             ins_rd, ins_wr, pend, busy_all;
  slot_t            head;

  always_comb begin
    ins_rd   = cmd_rd && !cfg_err;
    ins_wr   = cmd_wr && !cmd_rd && !cfg_err;
    short_b  = otf ? cmd_bc4 : bc4_fix;
    start    = (ins_rd ? rl : wl) - LAT_W'(1);
    busy_all = pend || cmd_rd || cmd_wr;
  end

  lat_cfg #(.RST_CL(RST_CL), .RST_CWL(RST_CWL)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .busy(busy_all),
    .cl_in(cfg_cl), .cwl_in(cfg_cwl), .al_in(cfg_al), .blm_in(cfg_blm),
    .rl(rl), .wl(wl), .bc4_fix(bc4_fix), .otf(otf),
    .cfg_err(cfg_err), .mode_rej(mode_rej)
  );

  lat_pipe #(.DEPTH(DEPTH)) u_pipe (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ins_rd(ins_rd), .ins_wr(ins_wr), .start(start), .short_b(short_b),
    .head(head), .busy(pend), .coll(collision_err)
  );

  always_comb begin
    rd_en      = head.rd;
    wr_en      = head.wr;
    beat_cnt   = (head.rd || head.wr) ? {head.idx, 1'b0} : 3'd0;
    burst_done = (head.rd || head.wr) && head.last;
  end

endmodule

// File: rtl/lat_chk.sv
module lat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flush,
  input logic       cfg_load,
  input logic       cmd_rd,
  input logic       cmd_wr,
  input logic       rd_en,
  input logic       wr_en,
  input logic [2:0] beat_cnt,
  input logic       burst_done,
  input logic       collision_err,
  input logic       cfg_err,
  input logic       mode_rej
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |-> (beat_cnt == 3'd0) && !burst_done); // R6

  AST_DONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (beat_cnt == 3'd2) || (beat_cnt == 3'd6)); // R6

  AST_COLL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    collision_err |-> $past(cmd_rd || cmd_wr)); // R8

  AST_REJ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rej |-> $past(cfg_load)); // R9

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_load) |-> $stable(cfg_err)); // R4

  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rd_en && !wr_en); // R10

endmodule

bind ddr3_lat_sched lat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .cfg_load(cfg_load),
  .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .rd_en(rd_en), .wr_en(wr_en),
  .beat_cnt(beat_cnt), .burst_done(burst_done),
  .collision_err(collision_err), .cfg_err(cfg_err), .mode_rej(mode_rej)
);

// File: tb/tb_ddr3_lat_sched.sv
module tb_ddr3_lat_sched;

  logic clk = 1'b0;
  logic rst_n, flush, cfg_load, cmd_rd, cmd_wr, cmd_bc4;
  logic [3:0] cfg_cl, cfg_cwl;
  logic [1:0] cfg_al, cfg_blm;
  logic rd_en, wr_en, burst_done, collision_err, cfg_err, mode_rej;
  logic [2:0] beat_cnt;
  int n_tests = 0;
  int n_fail  = 0;

  localparam logic [3:0] CL_TAB [9] = '{4'd5, 4'd6, 4'd7, 4'd8, 4'd9,
                                        4'd10, 4'd11, 4'd13, 4'd14};

  always #2.5 clk = ~clk;

  ddr3_lat_sched dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cfg_load(cfg_load),
    .cfg_cl(cfg_cl), .cfg_cwl(cfg_cwl), .cfg_al(cfg_al), .cfg_blm(cfg_blm),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_bc4(cmd_bc4),
    .rd_en(rd_en), .wr_en(wr_en), .beat_cnt(beat_cnt), .burst_done(burst_done),
    .collision_err(collision_err), .cfg_err(cfg_err), .mode_rej(mode_rej)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load(input int cl, input int cwl, input int al, input int blm);
    @(negedge clk);
    cfg_cl = 4'(cl); cfg_cwl = 4'(cwl); cfg_al = 2'(al); cfg_blm = 2'(blm);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // one command, then watch 45 cycles
  task automatic run_one(input string tag, input bit wr, input bit bc4,
                         input int exp_lat, input int exp_dur);
    int first, cnt, bad;
    first = -1; cnt = 0; bad = 0;
    @(negedge clk);
    cmd_rd = !wr; cmd_wr = wr; cmd_bc4 = bc4;
    for (int k = 1; k <= 45; k++) begin
      @(negedge clk);
      if (k == 1) begin cmd_rd = 1'b0; cmd_wr = 1'b0; cmd_bc4 = 1'b0; end
      if (wr ? rd_en : wr_en) bad++;
      if (wr ? wr_en : rd_en) begin
        if (first < 0) first = k;
        if (int'(beat_cnt) != 2 * cnt) bad++;
        cnt++;
        if (burst_done != (cnt == exp_dur)) bad++;
      end
    end
    check({tag, " latency"}, first, exp_lat);
    check({tag, " length"}, cnt, exp_dur);
    check({tag, " beats"}, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int al, lat, cwl, first, cnt, dn, seen;
    rst_n = 1'b0; flush = 1'b0; cfg_load = 1'b0; cmd_rd = 1'b0; cmd_wr = 1'b0;
    cmd_bc4 = 1'b0; cfg_cl = 4'd5; cfg_cwl = 4'd5; cfg_al = 2'd0; cfg_blm = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 idle outputs", int'({rd_en, wr_en, beat_cnt, burst_done, collision_err, mode_rej}), 0);
    check("R12 cfg_err", int'(cfg_err), 0);

    // R1 R2 R3 R5 sweep over the legal CL table
    for (int ci = 0; ci < 9; ci++) begin
      for (int a = 0; a < 3; a++) begin
        for (int b = 0; b < 2; b++) begin
          al  = (a == 0) ? 0 : int'(CL_TAB[ci]) - a;
          cwl = 5 + (ci % 6);
          load(int'(CL_TAB[ci]), cwl, a, b);
          run_one("R1 read sweep", 1'b0, 1'b0, int'(CL_TAB[ci]) + al, b ? 2 : 4);
          run_one("R2 write sweep", 1'b1, 1'b0, cwl + al, b ? 2 : 4);
        end
      end
    end

    // R5 per-command length
    load(6, 5, 0, 2);
    run_one("R5 otf chop", 1'b0, 1'b1, 6, 2);
    run_one("R5 otf full", 1'b1, 1'b0, 5, 4);

    // R4 R3 illegal settings
    load(12, 5, 0, 0);
    check("R4 cl 12 flagged", int'(cfg_err), 1);
    run_one("R4 ignored", 1'b0, 1'b0, -1, 0);
    load(5, 11, 0, 0);
    check("R4 cwl 11 flagged", int'(cfg_err), 1);
    load(5, 5, 3, 0);
    check("R3 al code 3 flagged", int'(cfg_err), 1);
    load(5, 5, 0, 0);
    check("R4 legal clears", int'(cfg_err), 0);

    // R7 seamless back-to-back reads
    first = -1; cnt = 0; dn = 0; seen = 0;
    @(negedge clk); cmd_rd = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      cmd_rd = (k == 4);
      if (rd_en) begin
        if (first < 0) first = k;
        if (int'(beat_cnt) != 2 * (cnt % 4)) seen++;
        cnt++;
      end
      if (burst_done) dn++;
    end
    check("R7 first", first, 5);
    check("R7 unbroken length", cnt, 8);
    check("R7 two ends", dn, 2);
    check("R6 beat order", seen, 0);

    // R8 read then write overlap
    first = 0; cnt = 0; seen = 0;
    @(negedge clk); cmd_rd = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      cmd_rd = 1'b0; cmd_wr = (k == 1);
      if (k == 2) seen = int'(collision_err);
      if (rd_en) first++;
      if (wr_en) cnt++;
    end
    check("R8 collision pulse", seen, 1);
    check("R8 read kept", first, 4);
    check("R8 write kept", cnt, 4);

    // R9 load while in flight is rejected
    @(negedge clk); cmd_rd = 1'b1;
    @(negedge clk); cmd_rd = 1'b0;
    cfg_cl = 4'd9; cfg_load = 1'b1;
    @(negedge clk); cfg_load = 1'b0;
    check("R9 reject pulse", int'(mode_rej), 1);
    repeat (12) @(negedge clk);
    run_one("R9 old CL kept", 1'b0, 1'b0, 5, 4);

    // R10 flush mid-window
    seen = 0;
    @(negedge clk); cmd_rd = 1'b1;
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      cmd_rd = 1'b0;
      flush = (k == 5) && rd_en;
      if (k > 5 && (rd_en || beat_cnt != 3'd0)) seen++;
    end
    flush = 1'b0;
    check("R10 cleared", seen, 0);

    // R11 read wins when both asserted
    load(5, 7, 0, 0);
    first = -1; cnt = 0;
    @(negedge clk); cmd_rd = 1'b1; cmd_wr = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      cmd_rd = 1'b0; cmd_wr = 1'b0;
      if (rd_en && first < 0) first = k;
      if (wr_en) cnt++;
    end
    check("R11 read scheduled", first, 5);
    check("R11 write dropped", cnt, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule